// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This block is an 8-bit up-counter that can act as a periodic interval timer or as a watchdog. A free-running prescaler divides the system clock. One of eight power-of-two taps, from /2 up to /8192, supplies the tick that advances the counter. When the counter wraps from 0xFF to 0x00 it signals an overflow.

An 8-bit control register sets what the overflow does. It can raise a sticky interrupt request. In watchdog mode it can also emit a one-cycle internal reset pulse, either of the power-on kind or of the manual kind. Software reaches the counter and the control register through one address bit, a write strobe, write data and a combinational read-data path.

In interval mode, software lets the counter wrap and services the interrupt. In watchdog mode, software rewrites the counter before it wraps. If it fails to do so, the chosen reset pulse fires.

Top module: `wdt_interval_timer`

## Requirements
- R1: While reset is held, and on the first cycles after its release, read data is 0x00 at both addresses, and the overflow, interrupt and both reset outputs are 0.
- R2: A write with `addr_i`=0 loads the counter, and a write with `addr_i`=1 loads the control register. The written value is returned on `rd_data_o` at the same address from the cycle after the write.
- R3: The counter advances only while control bit 5 (timer enable) is 1. With the bit at 0 the counter value holds.
- R4: Control bits [2:0] select the tick period in system-clock cycles: 000=2, 001=8, 010=32, 011=64, 100=256, 101=512, 110=2048, 111=8192. With the timer enabled, consecutive counter increments are exactly that many cycles apart.
- R5: A wrap of the counter from 0xFF to 0x00 drives `ovf_o` high for exactly one cycle, the cycle in which the counter first reads 0x00. This happens in both modes.
- R6: Control bit 6 selects the mode: 0 for interval, 1 for watchdog. In interval mode neither reset output ever pulses.
- R7: In watchdog mode with control bit 4 (reset enable) set, an overflow pulses one reset output for one cycle, in the same cycle as `ovf_o`. Control bit 3 picks the output: 0 drives `por_rst_o`, 1 drives `man_rst_o`. With bit 4 clear, neither output pulses.
- R8: With control bit 7 set, an overflow sets `irq_o`. The request stays high until software writes the counter (it is low from the next cycle) or clears bit 7 (it is low one cycle after the control register updates). With bit 7 clear, an overflow leaves `irq_o` low.
- R9: A counter write in the same cycle as a prescaler tick wins over the tick. The tick is dropped, and the counter holds the written value until the following tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 1 | Register select: 0 counter, 1 control |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data of the selected register |
| ovf_o | output | 1 | One-cycle overflow flag |
| irq_o | output | 1 | Sticky interrupt request |
| por_rst_o | output | 1 | One-cycle power-on-type reset request |
| man_rst_o | output | 1 | One-cycle manual-type reset request |

## Verification
The assertions take for granted that the tick from the prescaler never arrives on two adjacent cycles. They also assume that software changes the control byte only through the write port, so every reset pulse can be traced to a watchdog-mode control value one cycle earlier. The stimulus drives addresses and write strobes only between clock edges and issues each write as a single-cycle strobe. It places the contested write-versus-tick case on a known tick cycle by first observing an increment at the /2 tap. Overflow cases start from 0xFF with the timer briefly disabled, so each wrap happens within a couple of ticks and comes from a known control value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned DIV_SEL_W = 3;

  // Control byte layout, most significant bit first.
  typedef struct packed {
    logic                 irq_en;    // bit 7
    logic                 wd_mode;   // bit 6
    logic                 tmr_en;    // bit 5
    logic                 rst_en;    // bit 4
    logic                 rst_kind;  // bit 3: 0 power-on type, 1 manual type
    logic [DIV_SEL_W-1:0] div_sel;   // bits 2:0
  } ctrl_t;

  // Prescaler bit whose rising transition forms the tick for a divisor code.
  function automatic int unsigned tap_bit(input logic [DIV_SEL_W-1:0] sel);
    int unsigned b;
    case (sel)
      3'd0:    b = 0;
      3'd1:    b = 2;
      3'd2:    b = 4;
      3'd3:    b = 5;
      3'd4:    b = 7;
      3'd5:    b = 8;
      3'd6:    b = 10;
      default: b = 12;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int unsigned PRE_W = 13
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic                 tick_o
);

  localparam int unsigned EXT_W = PRE_W + 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [EXT_W-1:0] win_mask;
  logic [EXT_W-1:0] win_ones;
  int unsigned      tap;

  always_comb begin
    pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  // The tick marks the cycle whose increment sets the tap bit. It depends
  // only on the present count, so a tap change cannot add an edge.
  always_comb begin
    tap      = tap_bit(div_sel_i);
    win_mask = (EXT_W'(2) << tap) - EXT_W'(1);
    win_ones = (EXT_W'(1) << tap) - EXT_W'(1);
    tick_o   = ((EXT_W'(pre_q) & win_mask) == win_ones);
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             step;

  always_comb begin
    step   = en_i & tick_i & ~wr_i;
    wrap_o = step & (cnt_q == {CNT_W{1'b1}});
    cnt_d  = cnt_q;
    if (wr_i)      cnt_d = wr_data_i;
    else if (step) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R5
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_i) |=> $stable(cnt_q));

  // R9
  write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wr_data_i)));

endmodule

// File: rtl/wdt_events.sv
module wdt_events
  import wdt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wrap_i,
  input  logic  cnt_wr_i,
  input  ctrl_t ctrl_i,
  output logic  ovf_o,
  output logic  irq_o,
  output logic  por_o,
  output logic  man_o
);

  logic ovf_q, irq_q, por_q, man_q;
  logic ovf_d, irq_d, por_d, man_d;
  logic rst_hit;

  always_comb begin
    ovf_d   = wrap_i;
    rst_hit = wrap_i & ctrl_i.wd_mode & ctrl_i.rst_en;
    por_d   = rst_hit & ~ctrl_i.rst_kind;
    man_d   = rst_hit &  ctrl_i.rst_kind;
    if (cnt_wr_i || !ctrl_i.irq_en) irq_d = 1'b0;
    else                            irq_d = irq_q | wrap_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
      por_q <= 1'b0;
      man_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      irq_q <= irq_d;
      por_q <= por_d;
      man_q <= man_d;
    end
  end

  assign ovf_o = ovf_q;
  assign irq_o = irq_q;
  assign por_o = por_q;
  assign man_o = man_q;

  // R8
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(wrap_i));

  // R6
  rst_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_q || man_q) |-> $past(ctrl_i.wd_mode));

  // R7
  por_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_q |=> !por_q);

  // R7
  man_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_q |=> !man_q);

endmodule

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PRE_W       = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              por_rst_o,
  output logic              man_rst_o
);

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic              rst_n;
  logic              cnt_wr;
  logic              ctrl_wr;
  logic              tick;
  logic              wrap;
  logic [DATA_W-1:0] cnt;
  ctrl_t             ctrl_q;
  ctrl_t             ctrl_d;

  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  always_comb begin
    cnt_wr  = wr_en_i & ~addr_i;
    ctrl_wr = wr_en_i &  addr_i;
    ctrl_d  = ctrl_q;
    if (ctrl_wr) ctrl_d = ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  wdt_prescaler #(.PRE_W(PRE_W)) u_prescaler (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .div_sel_i (ctrl_q.div_sel),
    .tick_o    (tick)
  );

  wdt_counter #(.CNT_W(DATA_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .en_i      (ctrl_q.tmr_en),
    .tick_i    (tick),
    .wr_i      (cnt_wr),
    .wr_data_i (wr_data_i),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  wdt_events u_events (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wrap_i   (wrap),
    .cnt_wr_i (cnt_wr),
    .ctrl_i   (ctrl_q),
    .ovf_o    (ovf_o),
    .irq_o    (irq_o),
    .por_o    (por_rst_o),
    .man_o    (man_rst_o)
  );

  always_comb begin
    rd_data_o = addr_i ? DATA_W'(ctrl_q) : cnt;
  end

  // R2
  ctrl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q == $past(wr_data_i[CTRL_W-1:0])));

  // R5
  ovf_after_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(ovf_o) |-> (cnt == '0));

endmodule

// File: tb/wdt_interval_timer_tb.sv
`timescale 1ns/1ps
module wdt_interval_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       ovf, irq, por, man;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;

  always #2 clk = ~clk;

  wdt_interval_timer dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .ovf_o     (ovf),
    .irq_o     (irq),
    .por_rst_o (por),
    .man_rst_o (man)
  );

  // Overflow vectors: control byte (divisor 000 or 001), expected irq/por/man.
  localparam int N_OVF = 7;
  localparam logic [10:0] OVF_TBL [N_OVF] = '{
    {8'hA0, 3'b100},   // interval, irq on
    {8'hF0, 3'b110},   // watchdog, reset on, power-on type, irq on
    {8'hF8, 3'b101},   // watchdog, reset on, manual type, irq on
    {8'h60, 3'b000},   // watchdog, reset off, irq off
    {8'h38, 3'b000},   // interval with reset bits set
    {8'h78, 3'b001},   // watchdog manual, irq off
    {8'hF1, 3'b110}    // as case 2 at divisor /8
  };
  localparam int PERIOD_TBL [8] = '{2, 8, 32, 64, 256, 512, 2048, 8192};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      checks   = checks + 1;
      $display("FAIL watchdog expired actual=%0d cycles expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr    = a;
    wr_data = d;
    wr_en   = 1'b1;
    step();
    wr_en   = 1'b0;
    addr    = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a;
    #0.5;
    d    = rd_data;
    addr = 1'b0;
    #0.5;
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] prev;
    int         gap;
    bit         seen;

    rst_n = 1'b0; addr = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    repeat (3) step();
    // R1: reset state while held
    rd(1'b0, v); chk(v == 8'h00, "R1 counter in reset", v, 0);
    rd(1'b1, v); chk(v == 8'h00, "R1 control in reset", v, 0);
    chk({ovf, irq, por, man} == 4'b0, "R1 outputs in reset", {ovf, irq, por, man}, 0);
    rst_n = 1'b1;
    repeat (4) step();
    rd(1'b0, v); chk(v == 8'h00, "R1 counter after release", v, 0);
    chk({ovf, irq, por, man} == 4'b0, "R1 outputs after release", {ovf, irq, por, man}, 0);

    // R2: register load and read back
    wr(1'b0, 8'h5A);
    rd(1'b0, v); chk(v == 8'h5A, "R2 counter readback", v, 8'h5A);
    wr(1'b1, 8'h47);
    rd(1'b1, v); chk(v == 8'h47, "R2 control readback", v, 8'h47);

    // R3: disabled timer holds its value (divisor /2 would otherwise tick)
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h05);
    repeat (40) step();
    rd(1'b0, v); chk(v == 8'h05, "R3 hold while disabled", v, 5);
    wr(1'b1, 8'h20);
    repeat (10) step();
    rd(1'b0, v); chk(v == 8'h0A, "R3 counts once enabled", v, 8'h0A);

    // R4: increment spacing for each divisor code
    for (int s = 0; s < 8; s++) begin
      wr(1'b1, 8'h20 | 8'(s));
      wr(1'b0, 8'h00);
      rd(1'b0, prev);
      for (int k = 0; k < 3; k++) begin
        gap = 0;
        do begin
          step();
          gap++;
          rd(1'b0, v);
        end while (v == prev && gap < 9000);
        prev = v;
        if (k > 0)
          chk(gap == PERIOD_TBL[s], $sformatf("R4 period code %0d", s), gap, PERIOD_TBL[s]);
      end
    end

    // R5 R6 R7 R8: overflow vector table
    for (int i = 0; i < N_OVF; i++) begin
      logic [7:0] cb;
      logic [2:0] ex;
      cb = OVF_TBL[i][10:3];
      ex = OVF_TBL[i][2:0];
      wr(1'b1, cb & 8'hDF);
      wr(1'b0, 8'hFF);
      wr(1'b1, cb);
      seen = 1'b0;
      for (int c = 0; c < 20 && !seen; c++) begin
        step();
        if (ovf) seen = 1'b1;
        else chk({por, man} == 2'b00, $sformatf("R6 R7 no early reset case %0d", i), {por, man}, 0);
      end
      chk(seen, $sformatf("R5 overflow seen case %0d", i), seen, 1);
      rd(1'b0, v); chk(v == 8'h00, $sformatf("R5 wrapped value case %0d", i), v, 0);
      chk(irq == ex[2], $sformatf("R8 irq case %0d", i), irq, ex[2]);
      chk({por, man} == ex[1:0], $sformatf("R6 R7 reset pulse case %0d", i), {por, man}, ex[1:0]);
      step();
      chk({ovf, por, man} == 3'b000, $sformatf("R5 R7 single cycle case %0d", i), {ovf, por, man}, 0);
      chk(irq == ex[2], $sformatf("R8 irq sticky case %0d", i), irq, ex[2]);
    end

    // R8: sticky, then cleared by a counter write
    wr(1'b1, 8'h80 | 8'h20);
    wr(1'b0, 8'hFF);
    repeat (6) step();
    chk(irq == 1'b1, "R8 irq raised", irq, 1);
    repeat (20) step();
    chk(irq == 1'b1, "R8 irq stays high", irq, 1);
    wr(1'b0, 8'h10);
    chk(irq == 1'b0, "R8 cleared by counter write", irq, 0);
    // R8: cleared by dropping the enable bit
    wr(1'b0, 8'hFF);
    repeat (6) step();
    chk(irq == 1'b1, "R8 irq raised again", irq, 1);
    wr(1'b1, 8'h20);
    step();
    chk(irq == 1'b0, "R8 cleared by enable bit", irq, 0);

    // R9: counter write on a tick cycle drops the tick (divisor /2)
    wr(1'b1, 8'h20);
    rd(1'b0, prev);
    do begin
      step();
      rd(1'b0, v);
    end while (v == prev);
    // A tick was just taken; the next is two edges after it.
    step();
    wr(1'b0, 8'h40);
    rd(1'b0, v); chk(v == 8'h40, "R9 write wins on tick", v, 8'h40);
    step();
    rd(1'b0, v); chk(v == 8'h40, "R9 tick dropped", v, 8'h40);
    step();
    rd(1'b0, v); chk(v == 8'h41, "R9 next tick counts", v, 8'h41);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule